// File: doc/BRIEF.md
# Two-Channel Programmable Interval Timer

This block holds two 16-bit down-counters, channel 0 and channel 2. Both count on the cycles where a tick enable, at the nominal 1.19318 MHz timer rate, is high. Software sets a channel's mode with a control byte. It then loads that channel's count by writing two bytes to the channel's data port, low byte first. The count starts on the cycle the high byte arrives. A counter that expires sends a one-cycle pulse to the interrupt controller. In mode 0 the channel stops after one expiry. In every other mode it reloads and runs again. Channel 2's status byte can be read at any time. Bit 5 of that byte reports terminal count after a one-shot run.

The byte-pair sequencer has two states. In `SEQ_LO` a data write stores the low byte and moves to `SEQ_HI`. In `SEQ_HI` a data write supplies the high byte, starts the addressed channel and returns to `SEQ_LO`. Only one such pending flag exists, and both channels share it. Each channel has three states. It moves from `CH_IDLE` to `CH_RUN` on a start. It stays in `CH_RUN` on a periodic expiry, or when restarted. It moves from `CH_RUN` to `CH_DONE` when it expires in mode 0. It moves from `CH_DONE` back to `CH_RUN` on a new start.

Top module: `interval_timer_pair`

## Requirements
- R1: After reset the status byte reads 0x00, `ctl_err_o` and `expire_o` are low, and both channels are in `CH_IDLE`. Ticks alone produce no expiry.
- R2: A control write (`wr_port` = 0) whose bits [5:4] are not 2'b11 raises `ctl_err_o` for exactly the cycle after the write edge. It changes no channel mode.
- R3: Control bits [7:6] pick the channel: 2'b00 picks channel 0 and 2'b10 picks channel 2. The values 2'b01 and 2'b11 raise `ctl_err_o` the same way and change no mode. A legal control write leaves `ctl_err_o` low.
- R4: A legal control write sets the picked channel's mode to control bits [3:1]. Bit 0 is ignored.
- R5: Data writes go to `wr_port` = 1 for channel 0 and `wr_port` = 2 for channel 2. The first data write stores the low byte. The next data write, to either port, supplies the high byte and starts the channel named by that second write's port.
- R6: A start loads the 16-bit count and clears that channel's status to 0x00. This applies even while the channel is running or has finished.
- R7: The counter decrements only on cycles with `tick_en` high. If a start happens at edge k and every cycle ticks, the expiry falls on edge k+N. A loaded count of 0 acts as 65536.
- R8: In mode 0 an expiry sets the status to 0x20 on the same edge and halts the channel. There are no further expiries until the next start.
- R9: In any nonzero mode an expiry reloads the last loaded count, so the channel expires every N ticks.
- R10: `status_o` shows channel 2's status only. `expire_o[0]` belongs to channel 0 and `expire_o[1]` to channel 2. Each is high for one cycle per expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer-rate count enable |
| wr_en | input | 1 | Byte write strobe |
| wr_port | input | 2 | 0 = control, 1 = channel 0 data, 2 = channel 2 data, 3 = none |
| wr_data | input | BYTE_W | Written byte |
| status_o | output | BYTE_W | Channel 2 status byte |
| ctl_err_o | output | 1 | One-cycle flag for a rejected control byte |
| expire_o | output | 2 | Per-channel expiry pulse (bit 1 = channel 2) |

## Verification
Inputs change just after a falling edge and outputs are read on the next falling edge. A control error therefore shows at the first falling edge after the write. The bench starts counting at the falling edge that follows the high-byte write edge, and expects the expiry pulse at the N-th falling edge after that. This is because the count register, the expiry register and the status register all update on the same edge k+N. In periodic runs the pulse must appear at exactly every N-th falling edge, with no pulse in between. Each one-shot run is followed by a quiet window that must show no pulse.

// File: rtl/itv_pkg.sv
package itv_pkg;
    typedef enum logic [1:0] {
        PORT_CTRL = 2'd0,
        PORT_CH0  = 2'd1,
        PORT_CH2  = 2'd2,
        PORT_NONE = 2'd3
    } port_e;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_DONE = 2'd2
    } ch_state_e;

    typedef enum logic {
        SEQ_LO = 1'b0,
        SEQ_HI = 1'b1
    } seq_state_e;

    localparam int MODE_W = 3;
    localparam int NCH    = 2;
    localparam logic [7:0] TC_STATUS = 8'h20;
endpackage

// File: rtl/itv_ctl_dec.sv
module itv_ctl_dec
    import itv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic [7:1]        ctl_bits,
    output logic [NCH-1:0]    mode_we,
    output logic [MODE_W-1:0] mode_val,
    output logic              err_o
);
    logic bad;
    logic err_q;

    always_comb begin
        mode_we  = '0;
        bad      = 1'b0;
        mode_val = ctl_bits[3:1];
        if (wr_ctl) begin
            if (ctl_bits[5:4] != 2'b11) begin
                bad = 1'b1;
            end else begin
                unique case (ctl_bits[7:6])
                    2'b00:   mode_we[0] = 1'b1;
                    2'b10:   mode_we[1] = 1'b1;
                    default: bad = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= bad;
    end

    assign err_o = err_q;

    // R2 / R3: the error flag follows a control write and never comes with a mode update
    a_r2_err_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> $past(wr_ctl));
    a_r3_err_no_mode: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we != '0 |=> !err_q);
endmodule

// File: rtl/itv_load_seq.sv
module itv_load_seq
    import itv_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data_en,
    input  logic              wr_ch,
    input  logic [BYTE_W-1:0] data,
    output logic [NCH-1:0]    start,
    output logic [CNT_W-1:0]  load_val
);
    seq_state_e        state, nxt;
    logic [BYTE_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_LO;
            lo_q  <= '0;
        end else begin
            state <= nxt;
            if (state == SEQ_LO && wr_data_en) lo_q <= data;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SEQ_LO: if (wr_data_en) nxt = SEQ_HI;
            SEQ_HI: if (wr_data_en) nxt = SEQ_LO;
            default: nxt = SEQ_LO;
        endcase
    end

    always_comb begin
        start    = '0;
        load_val = {data, lo_q};
        if (state == SEQ_HI && wr_data_en) start[wr_ch] = 1'b1;
    end

    // R5: the pending flag holds until the next data write; one start at a time
    a_r5_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_HI && !wr_data_en) |=> state == SEQ_HI);
    a_r5_start_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start));
endmodule

// File: rtl/itv_chan.sv
module itv_chan
    import itv_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [CNT_W-1:0]  load_val,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_val,
    output logic [STAT_W-1:0] status,
    output logic              expire
);
    ch_state_e         state, nxt;
    logic [CNT_W-1:0]  cnt_q, reload_q;
    logic [MODE_W-1:0] mode_q;
    logic [STAT_W-1:0] status_q;
    logic              expire_q;
    logic              at_end;
    logic              one_shot;

    assign one_shot = (mode_q == '0);
    assign at_end   = (state == CH_RUN) && tick && !start && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CH_IDLE: if (start) nxt = CH_RUN;
            CH_RUN:  if (!start && at_end && one_shot) nxt = CH_DONE;
            CH_DONE: if (start) nxt = CH_RUN;
            default: nxt = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            reload_q <= '0;
            mode_q   <= '0;
            status_q <= '0;
            expire_q <= 1'b0;
        end else begin
            expire_q <= at_end;
            if (mode_we) mode_q <= mode_val;
            if (start) begin
                cnt_q    <= load_val;
                reload_q <= load_val;
                status_q <= '0;
            end else if (state == CH_RUN && tick) begin
                cnt_q <= at_end ? reload_q : cnt_q - CNT_W'(1);
                if (at_end && one_shot) status_q <= STAT_W'(TC_STATUS);
            end
        end
    end

    assign status = status_q;
    assign expire = expire_q;

    a_r6_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == $past(load_val) && status_q == '0 && state == CH_RUN));
    a_r7_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_RUN && !tick && !start) |=> $stable(cnt_q));
    a_r8_done_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_DONE && !start) |=> (!expire_q && state == CH_DONE));
    a_r8_done_status: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_q && state == CH_DONE) |-> status_q == STAT_W'(TC_STATUS));
    a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_q && state == CH_RUN) |-> cnt_q == reload_q);
endmodule

// File: rtl/interval_timer_pair.sv
module interval_timer_pair
    import itv_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [1:0]        wr_port,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] status_o,
    output logic              ctl_err_o,
    output logic [NCH-1:0]    expire_o
);
    localparam int CNT_W = 2 * BYTE_W;

    port_e             port;
    logic              wr_ctl, wr_data_en, wr_ch;
    logic [NCH-1:0]    mode_we, start;
    logic [MODE_W-1:0] mode_val;
    logic [CNT_W-1:0]  load_val;
    logic [BYTE_W-1:0] stat_all [NCH];

    assign port       = port_e'(wr_port);
    assign wr_ctl     = wr_en && (port == PORT_CTRL);
    assign wr_data_en = wr_en && (port == PORT_CH0 || port == PORT_CH2);
    assign wr_ch      = (port == PORT_CH2);

    itv_ctl_dec u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctl   (wr_ctl),
        .ctl_bits (wr_data[7:1]),
        .mode_we  (mode_we),
        .mode_val (mode_val),
        .err_o    (ctl_err_o)
    );

    itv_load_seq #(.BYTE_W(BYTE_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_data_en (wr_data_en),
        .wr_ch      (wr_ch),
        .data       (wr_data),
        .start      (start),
        .load_val   (load_val)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        itv_chan #(.CNT_W(CNT_W), .STAT_W(BYTE_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick_en),
            .start    (start[g]),
            .load_val (load_val),
            .mode_we  (mode_we[g]),
            .mode_val (mode_val),
            .status   (stat_all[g]),
            .expire   (expire_o[g])
        );
    end

    assign status_o = stat_all[1];

    // R10: a status byte only ever holds the cleared or terminal-count value
    a_r10_ch0_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_all[0] == '0) || (stat_all[0] == BYTE_W'(TC_STATUS)));
    a_r10_ch2_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == '0) || (status_o == BYTE_W'(TC_STATUS)));
endmodule

// File: tb/test_interval_timer_pair.sv
module test_interval_timer_pair;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_port = 2'd3;
    logic [7:0] wr_data = '0;
    logic [7:0] status_o;
    logic       ctl_err_o;
    logic [1:0] expire_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    interval_timer_pair i_interval_timer_pair (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_port(wr_port), .wr_data(wr_data), .status_o(status_o),
        .ctl_err_o(ctl_err_o), .expire_o(expire_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] p, input logic [7:0] d);
        wr_en = 1'b1; wr_port = p; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_port = 2'd3;
    endtask

    task automatic load(input logic [1:0] p, input int v);
        wr(p, v[7:0]);
        wr(p, v[15:8]);
    endtask

    // waits for the first pulse on channel bit ch; returns falling edges counted
    task automatic wait_exp(input int ch, input int limit, output int j);
        j = 0;
        for (int k = 1; k <= limit; k++) begin
            @(negedge clk);
            if (expire_o[ch]) begin j = k; break; end
        end
    endtask

    task automatic quiet(input int ch, input int cycles, input string req);
        int seen = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (expire_o[ch]) seen++;
        end
        chk(req, seen, 0);
    endtask

    initial begin
        int j;
        int lens [12] = '{1, 2, 3, 4, 5, 6, 7, 8, 100, 255, 256, 257};
        int per [4] = '{1, 2, 5, 13};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 status", status_o, 0);
        chk("R1 err", ctl_err_o, 0);
        chk("R1 expire", expire_o, 0);
        tick_en = 1'b1;
        quiet(0, 20, "R1 ch0 idle");
        quiet(1, 1, "R1 ch2 idle");

        // R2 / R3 exhaustive control byte sweep
        for (int b = 0; b < 256; b++) begin
            logic [7:0] c = 8'(b);
            int bad = (c[5:4] != 2'b11) || (c[7:6] == 2'b01) || (c[7:6] == 2'b11);
            wr(2'd0, c);
            chk(bad ? "R2 R3 rejected control" : "R3 legal control", ctl_err_o, bad);
        end

        // R2 / R3 / R4 / R8: illegal bytes leave channel 2 in one-shot mode
        wr(2'd0, 8'hB1);          // ch2, mode 0, bit0 set and ignored (R4)
        wr(2'd0, 8'h84);          // bits[5:4]=00, would be mode 2
        wr(2'd0, 8'hF4);          // select 11
        wr(2'd0, 8'h74);          // select 01
        load(2'd2, 3);
        wait_exp(1, 10, j);
        chk("R2 R3 ignored, one-shot count 3", j, 3);
        chk("R8 status tc", status_o, 32);
        quiet(1, 12, "R8 halted after expiry");

        // R6 R7 R8 one-shot sweep on channel 2
        foreach (lens[i]) begin
            load(2'd2, lens[i]);
            chk("R6 status cleared on start", status_o, 0);
            wait_exp(1, 400, j);
            chk("R7 one-shot length", j, lens[i]);
            chk("R8 status after expiry", status_o, 32);
            quiet(1, 4, "R8 no second expiry");
        end

        // R4 R9 periodic on channel 0, mode 2
        wr(2'd0, 8'h34);
        foreach (per[i]) begin
            int errs = 0;
            load(2'd1, per[i]);
            for (int k = 1; k <= 3 * per[i]; k++) begin
                @(negedge clk);
                if (expire_o[0] != ((k % per[i]) == 0)) errs++;
            end
            chk("R9 periodic pulse spacing", errs, 0);
        end
        wr(2'd0, 8'h30);          // back to one-shot; let ch0 finish
        load(2'd1, 2);
        wait_exp(0, 5, j);
        chk("R4 mode 0 restored", j, 2);

        // R4 R9 R10 mode 3 on channel 2: periodic, status stays 0, ch0 silent
        wr(2'd0, 8'hB6);
        load(2'd2, 4);
        begin
            int errs = 0;
            for (int k = 1; k <= 12; k++) begin
                @(negedge clk);
                if (expire_o[1] != ((k % 4) == 0)) errs++;
                if (expire_o[0]) errs++;
                if (status_o != 0) errs++;
            end
            chk("R9 R10 mode 3 periodic, status 0", errs, 0);
        end
        wr(2'd0, 8'hB0);
        load(2'd2, 1);
        wait_exp(1, 3, j);
        chk("R10 ch2 stopped", j, 1);

        // R7 tick gating on channel 0 (mode 0)
        tick_en = 1'b0;
        load(2'd1, 5);
        quiet(0, 50, "R7 no count without tick");
        tick_en = 1'b1;
        wait_exp(0, 10, j);
        chk("R7 expiry after enabled ticks", j, 5);
        chk("R10 ch0 expiry leaves ch2 status", status_o, 32);

        // R5 shared pending flag: low to ch0 port, high to ch2 port
        wr(2'd1, 8'h06);
        wr(2'd2, 8'h00);
        chk("R6 ch2 status cleared", status_o, 0);
        begin
            int saw0 = 0;
            j = 0;
            for (int k = 1; k <= 10; k++) begin
                @(negedge clk);
                if (expire_o[0]) saw0++;
                if (expire_o[1] && j == 0) j = k;
            end
            chk("R5 second write port starts ch2", j, 6);
            chk("R5 ch0 not started", saw0, 0);
        end

        // R6 restart mid-count
        load(2'd2, 10);
        repeat (4) @(negedge clk);
        chk("R6 no early expiry", expire_o[1], 0);
        load(2'd2, 3);
        wait_exp(1, 20, j);
        chk("R6 restart reloads", j, 3);

        // R7 count 0 acts as 65536
        load(2'd1, 0);
        wait_exp(0, 70000, j);
        chk("R7 zero count length", j, 65536);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule